// File: doc/BRIEF.md
# Interrupt Event Ring Logger

This block turns interrupt events into entries in a circular log held in a small internal RAM. There are two kinds of event. Message events are qualified twice: once by the global enable word and once by the enable bits of the command that was just handled. Hardware events are qualified by the global enable word alone. All qualified events that arrive in one clock cycle form a single entry. Each entry takes two consecutive words of the ring. The first is an identification word with one bit per event type. The second is an address word that names the descriptor of the command that raised the message event.

The ring holds 16 entries in 32 words, which occupy buffer addresses 0x40 to 0x5F. A host-visible log register gives two things: the identification-word address where the next entry will go, and how many entries have been written since the host last read the register. A sticky pending register collects every logged event bit and drives a level interrupt output. The host clears the pending register by reading it. The host reads back logged words through a combinational buffer port.

Top module: `irq_ring_logger`

## Requirements
- R1: After reset the log register reads 0x0040, the pending register reads 0x0000 and irq_o is low.
- R2: A message event bit is logged only when its global enable bit and its command enable bit are both set. Otherwise no entry is written and no pending bit is set.
- R3: A hardware event bit is logged whenever its global enable bit is set, whatever the command enable bits hold.
- R4: msg_evt_i bits 4,3,2,1,0 map to identification bits 15,14,13,10,8. hw_evt_i bits 7:0 map to identification bits 7:0. Identification bits 12, 11 and 9 are always 0. glb_en_i uses the same bit positions.
- R5: The address word sits at the identification-word address plus 1. It holds desc_addr_i when the entry contains at least one message bit, and 0x0000 when the entry holds hardware bits only.
- R6: The next-entry address in log register bits 7:0 advances by 2 with each entry, and wraps from 0x5E back to 0x40.
- R7: The ring keeps the 16 most recent entries. The 17th entry overwrites the oldest one at 0x40/0x41.
- R8: Log register bits 15:8 count entries and saturate at 255.
- R9: A cycle with log_rd_i high returns the current count. The count then reads 0 on the next clock, or 1 if an entry is written in that same cycle.
- R10: Pending bits are set by logged identification bits and stay set until a cycle with pend_rd_i high clears them. Bits logged in that read cycle remain set.
- R11: irq_o is high exactly when any pending bit is set.
- R12: Events that are qualified in the same cycle merge into one identification word and one entry.
- R13: Buffer reads at addresses outside 0x40 to 0x5F return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en_i | input | 16 | Global enable word, in identification bit positions |
| cmd_en_i | input | 5 | Enable bits of the last command, one per message event |
| msg_evt_i | input | 5 | Message event strobes |
| desc_addr_i | input | 16 | Descriptor address of the last command |
| hw_evt_i | input | 8 | Hardware event strobes |
| log_rd_i | input | 1 | Host read of the log register |
| log_reg_o | output | 16 | {count[7:0], next identification address[7:0]} |
| pend_rd_i | input | 1 | Host read of the pending register |
| pend_o | output | 16 | Pending interrupt bits |
| irq_o | output | 1 | Interrupt output |
| buf_addr_i | input | 8 | Buffer read address |
| buf_data_o | output | 16 | Buffer read data |

## Verification
The case hardest to reach from the ports is count saturation, because it takes hundreds of entries with no host read in between. The stimulus holds one hardware event high for 300 cycles in a row, so 300 entries are written back to back. The pointer then lands at a known slot, and the count must stay at 255. Two other races are produced by asserting a host read in the same cycle as a new event: one with the log register, one with the pending register. This shows that the new event survives the clear.

// File: rtl/irq_log_pkg.sv
package irq_log_pkg;
  localparam int WORD_W = 16;
  localparam int MSG_N  = 5;
  localparam int HW_N   = 8;

  typedef struct packed {
    logic [WORD_W-1:0] addr_w;
    logic [WORD_W-1:0] id_w;
  } entry_t;

  // message strobe bit -> identification bit position
  function automatic logic [WORD_W-1:0] msg_to_id(input logic [MSG_N-1:0] m);
    logic [WORD_W-1:0] w;
    w     = '0;
    w[15] = m[4];
    w[14] = m[3];
    w[13] = m[2];
    w[10] = m[1];
    w[8]  = m[0];
    return w;
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irq_evt_gate.sv
module irq_evt_gate
  import irq_log_pkg::*;
(
  input  logic [WORD_W-1:0] glb_en,
  input  logic [MSG_N-1:0]  cmd_en,
  input  logic [MSG_N-1:0]  msg_evt,
  input  logic [WORD_W-1:0] desc_addr,
  input  logic [HW_N-1:0]   hw_evt,
  output entry_t            entry,
  output logic              vld
);
  logic [WORD_W-1:0] msg_w;
  logic [WORD_W-1:0] hw_w;

  always_comb begin
    msg_w        = msg_to_id(msg_evt & cmd_en) & glb_en;
    hw_w         = {{(WORD_W-HW_N){1'b0}}, hw_evt} & glb_en;
    entry.id_w   = msg_w | hw_w;
    entry.addr_w = (|msg_w) ? desc_addr : '0;
    vld          = |entry.id_w;
  end
endmodule

// File: rtl/irq_log_ptr.sv
module irq_log_ptr #(
  parameter int          ENTRIES = 16,
  parameter int          CNT_W   = 8,
  parameter logic [7:0]  BASE    = 8'h40,
  localparam int         IDX_W   = $clog2(ENTRIES),
  localparam logic [7:0] LAST    = BASE + 8'(2*(ENTRIES-1))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             log_en,
  input  logic             rd_clr,
  output logic [7:0]       ptr,
  output logic [CNT_W-1:0] cnt,
  output logic [IDX_W-1:0] idx
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [7:0]       ptr_q, ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       off;

  always_comb begin
    ptr_d = ptr_q;
    if (log_en) ptr_d = (ptr_q == LAST) ? BASE : ptr_q + 8'd2;

    cnt_d = cnt_q;
    if (rd_clr)                         cnt_d = log_en ? CNT_W'(1) : '0;
    else if (log_en && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;

    off = ptr_q - BASE;
    idx = off[IDX_W:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= BASE;
      cnt_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      cnt_q <= cnt_d;
    end
  end

  assign ptr = ptr_q;
  assign cnt = cnt_q;
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_log_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [WORD_W-1:0] set_bits,
  input  logic              rd_clr,
  output logic [WORD_W-1:0] pend,
  output logic              irq
);
  logic [WORD_W-1:0] pend_q, pend_d;
  logic              irq_q, irq_d;

  always_comb begin
    pend_d = rd_clr ? '0 : pend_q;
    if (set_en) pend_d = pend_d | set_bits;
    irq_d  = |pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  assign pend = pend_q;
  assign irq  = irq_q;
endmodule

// File: rtl/irq_log_ram.sv
module irq_log_ram
  import irq_log_pkg::*;
#(
  parameter int          ENTRIES = 16,
  parameter logic [7:0]  BASE    = 8'h40,
  localparam int         IDX_W   = $clog2(ENTRIES),
  localparam logic [8:0] TOP     = {1'b0, BASE} + 9'(2*ENTRIES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  entry_t            wdata,
  input  logic [7:0]        raddr,
  output logic [WORD_W-1:0] rdata
);
  entry_t     mem [ENTRIES];
  logic [7:0] roff;
  logic       in_rng;
  entry_t     rent;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_comb begin
    in_rng = ({1'b0, raddr} >= {1'b0, BASE}) && ({1'b0, raddr} < TOP);
    roff   = raddr - BASE;
    rent   = mem[roff[IDX_W:1]];
    if (!in_rng)      rdata = '0;
    else if (roff[0]) rdata = rent.addr_w;
    else              rdata = rent.id_w;
  end
endmodule

// File: rtl/irq_ring_logger.sv
module irq_ring_logger
  import irq_log_pkg::*;
#(
  parameter int         ENTRIES   = 16,
  parameter int         CNT_W     = 8,
  parameter logic [7:0] BASE_ADDR = 8'h40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] glb_en_i,
  input  logic [4:0]  cmd_en_i,
  input  logic [4:0]  msg_evt_i,
  input  logic [15:0] desc_addr_i,
  input  logic [7:0]  hw_evt_i,
  input  logic        log_rd_i,
  output logic [15:0] log_reg_o,
  input  logic        pend_rd_i,
  output logic [15:0] pend_o,
  output logic        irq_o,
  input  logic [7:0]  buf_addr_i,
  output logic [15:0] buf_data_o
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic             rst_sync_n;
  entry_t           ev_entry;
  logic             ev_vld;
  logic [7:0]       ptr;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] widx;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_evt_gate u_gate (
    .glb_en    (glb_en_i),
    .cmd_en    (cmd_en_i),
    .msg_evt   (msg_evt_i),
    .desc_addr (desc_addr_i),
    .hw_evt    (hw_evt_i),
    .entry     (ev_entry),
    .vld       (ev_vld)
  );

  irq_log_ptr #(.ENTRIES(ENTRIES), .CNT_W(CNT_W), .BASE(BASE_ADDR)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .log_en (ev_vld),
    .rd_clr (log_rd_i),
    .ptr    (ptr),
    .cnt    (cnt),
    .idx    (widx)
  );

  irq_pend_reg u_pend (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_en   (ev_vld),
    .set_bits (ev_entry.id_w),
    .rd_clr   (pend_rd_i),
    .pend     (pend_o),
    .irq      (irq_o)
  );

  irq_log_ram #(.ENTRIES(ENTRIES), .BASE(BASE_ADDR)) u_ram (
    .clk   (clk),
    .we    (ev_vld),
    .widx  (widx),
    .wdata (ev_entry),
    .raddr (buf_addr_i),
    .rdata (buf_data_o)
  );

  assign log_reg_o = {8'(cnt), ptr};
endmodule

// File: rtl/irq_ring_logger_chk.sv
module irq_ring_logger_chk #(
  parameter int         ENTRIES = 16,
  parameter logic [7:0] BASE    = 8'h40
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_vld,
  input logic        log_rd,
  input logic        pend_rd,
  input logic [15:0] log_reg,
  input logic [15:0] pend,
  input logic        irq
);
  localparam logic [7:0] LAST = BASE + 8'(2*(ENTRIES-1));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_vld) |-> log_reg[7:0] ==
      (($past(log_reg[7:0]) == LAST) ? BASE : $past(log_reg[7:0]) + 8'd2));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ev_vld) |-> $stable(log_reg[7:0]));

  // R8
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(log_rd) |-> log_reg[15:8] >= $past(log_reg[15:8]));

  // R9
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(log_rd) && !$past(ev_vld)) |-> log_reg[15:8] == 8'd0);

  // R10
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pend_rd) |-> (pend & $past(pend)) == $past(pend));

  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_vld));
endmodule

bind irq_ring_logger irq_ring_logger_chk #(.ENTRIES(ENTRIES), .BASE(BASE_ADDR)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .ev_vld  (ev_vld),
  .log_rd  (log_rd_i),
  .pend_rd (pend_rd_i),
  .log_reg (log_reg_o),
  .pend    (pend_o),
  .irq     (irq_o)
);

// File: tb/test_irq_ring_logger.sv
module test_irq_ring_logger;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [15:0] glb_en;
  logic [4:0]  cmd_en;
  logic [4:0]  msg_evt;
  logic [15:0] desc;
  logic [7:0]  hw_evt;
  logic        log_rd;
  logic [15:0] log_reg;
  logic        pend_rd;
  logic [15:0] pend;
  logic        irq;
  logic [7:0]  baddr;
  logic [15:0] bdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  irq_ring_logger i_irq_ring_logger (
    .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en), .cmd_en_i(cmd_en),
    .msg_evt_i(msg_evt), .desc_addr_i(desc), .hw_evt_i(hw_evt),
    .log_rd_i(log_rd), .log_reg_o(log_reg), .pend_rd_i(pend_rd),
    .pend_o(pend), .irq_o(irq), .buf_addr_i(baddr), .buf_data_o(bdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_buf(input logic [7:0] a, output logic [15:0] d);
    baddr = a;
    #1;
    d = bdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; glb_en = '0; cmd_en = '0; msg_evt = '0; desc = '0;
    hw_evt = '0; log_rd = 1'b0; pend_rd = 1'b0; baddr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic fire(input logic [4:0] m, input logic [7:0] h);
    @(negedge clk);
    msg_evt = m; hw_evt = h;
    @(negedge clk);
    msg_evt = '0; hw_evt = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 log reg", log_reg, 16'h0040);
    chk("R1 pending", pend, 16'h0000);
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_msg_gate();
    logic [15:0] d;
    do_reset();
    desc = 16'hA5C3;
    glb_en = 16'hFFFF; cmd_en = 5'b00000;
    fire(5'b10000, 8'h00);
    chk("R2 no cmd enable log", log_reg, 16'h0040);
    chk("R2 no cmd enable pend", pend, 16'h0000);
    glb_en = 16'h0000; cmd_en = 5'b11111;
    fire(5'b10000, 8'h00);
    chk("R2 no global enable log", log_reg, 16'h0040);
    glb_en = 16'hFFFF;
    fire(5'b10000, 8'h00);
    chk("R2 both enables log", log_reg, 16'h0142);
    chk("R10 pend set", pend, 16'h8000);
    chk("R11 irq high", irq, 1'b1);
    rd_buf(8'h40, d); chk("R4 id word", d, 16'h8000);
    rd_buf(8'h41, d); chk("R5 addr word message", d, 16'hA5C3);
  endtask

  task automatic t_hw_gate();
    logic [15:0] d;
    do_reset();
    desc = 16'h1234; cmd_en = 5'b00000; glb_en = 16'h00FF;
    fire(5'b00000, 8'h81);
    chk("R3 hw logged", log_reg, 16'h0142);
    rd_buf(8'h40, d); chk("R3 hw id word", d, 16'h0081);
    rd_buf(8'h41, d); chk("R5 addr word hw only", d, 16'h0000);
    glb_en = 16'h0001;
    fire(5'b00000, 8'h03);
    rd_buf(8'h42, d); chk("R3 hw global mask", d, 16'h0001);
  endtask

  task automatic t_merge();
    logic [15:0] d;
    do_reset();
    desc = 16'h0BEE; glb_en = 16'hFFFF; cmd_en = 5'b11111;
    fire(5'b11111, 8'hFF);
    chk("R12 single entry", log_reg, 16'h0142);
    rd_buf(8'h40, d); chk("R4 bit positions", d, 16'hE5FF);
    rd_buf(8'h41, d); chk("R12 merged addr word", d, 16'h0BEE);
    chk("R10 merged pend", pend, 16'hE5FF);
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    do_reset();
    glb_en = 16'hFFFF;
    for (int i = 0; i < 15; i++) fire(5'b0, 8'(i + 1));
    chk("R6 last slot", log_reg, 16'h0F5E);
    fire(5'b0, 8'h10);
    chk("R6 wrap", log_reg, 16'h1040);
    fire(5'b0, 8'h11);
    chk("R6 after wrap", log_reg, 16'h1142);
    rd_buf(8'h40, d); chk("R7 oldest overwritten", d, 16'h0011);
    rd_buf(8'h42, d); chk("R7 second kept", d, 16'h0002);
    rd_buf(8'h5E, d); chk("R7 sixteenth kept", d, 16'h0010);
  endtask

  task automatic t_sat();
    do_reset();
    glb_en = 16'hFFFF;
    @(negedge clk); hw_evt = 8'h01;
    repeat (300) @(negedge clk);
    hw_evt = 8'h00;
    chk("R8 count saturates", log_reg, 16'hFF58);
  endtask

  task automatic t_rd_clr();
    do_reset();
    glb_en = 16'hFFFF;
    repeat (3) fire(5'b0, 8'h02);
    @(negedge clk); log_rd = 1'b1;
    chk("R9 read value", log_reg, 16'h0346);
    @(negedge clk); log_rd = 1'b0;
    chk("R9 cleared", log_reg, 16'h0046);
    @(negedge clk); log_rd = 1'b1; hw_evt = 8'h01;
    @(negedge clk); log_rd = 1'b0; hw_evt = 8'h00;
    chk("R9 read with event", log_reg, 16'h0148);
  endtask

  task automatic t_pend();
    do_reset();
    glb_en = 16'hFFFF;
    fire(5'b0, 8'h01);
    fire(5'b0, 8'h02);
    chk("R10 sticky", pend, 16'h0003);
    @(negedge clk); pend_rd = 1'b1; hw_evt = 8'h04;
    @(negedge clk); pend_rd = 1'b0; hw_evt = 8'h00;
    chk("R10 new bit survives read", pend, 16'h0004);
    chk("R11 irq stays", irq, 1'b1);
    @(negedge clk); pend_rd = 1'b1;
    @(negedge clk); pend_rd = 1'b0;
    chk("R10 cleared", pend, 16'h0000);
    chk("R11 irq low", irq, 1'b0);
  endtask

  task automatic t_range();
    logic [15:0] d;
    do_reset();
    glb_en = 16'hFFFF;
    for (int i = 0; i < 16; i++) fire(5'b0, 8'hFF);
    rd_buf(8'h3F, d); chk("R13 below range", d, 16'h0000);
    rd_buf(8'h60, d); chk("R13 above range", d, 16'h0000);
    rd_buf(8'h5E, d); chk("R13 top slot readable", d, 16'h00FF);
  endtask

  initial begin
    t_reset();
    t_msg_gate();
    t_hw_gate();
    t_merge();
    t_wrap();
    t_sat();
    t_rd_clr();
    t_pend();
    t_range();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule